// File: doc/BRIEF.md
# H-Bridge Current-Chopping PWM Controller

This block holds the digital control for one H-bridge that drives a motor winding. A free-running counter divides time into fixed PWM periods. At the start of each period, and whenever the bridge is newly enabled, the bridge drives current along the diagonal that the direction input selects. An external analog comparator watches the winding current. After a blanking window, a trip from that comparator ends the drive phase. The bridge then decays until the next period begins. In fast decay the drive polarity is reversed, and the bridge turns fully off once a near-zero-current signal arrives. In slow decay both low-side switches recirculate the current.

The same decay-mode select sets the disabled state. With enable low, fast mode lets the motor coast with every switch off, and slow mode brakes it with both low sides on. A 2-bit scale code drives the DAC that sets the comparator reference, and code 11 shuts the bridge off. A fault input forces every gate off. The comparator and near-zero inputs are asynchronous and pass through two-flop synchronizers. Each leg has a guard, so one switch never hands over directly to the other switch on the same leg.

Top module: `hbridge_chop_ctrl`

## Requirements
- R1: While reset is held, all four gate outputs are low and `dac_sel_o` is 00.
- R2: In the drive phase, `dir_i`=1 turns on the leg-A high side and the leg-B low side. `dir_i`=0 turns on the leg-B high side and the leg-A low side.
- R3: Each PWM period of `PERIOD_CYC` clocks restarts the drive phase after a decay, as long as the bridge remains enabled.
- R4: For the first `BLANK_CYC` cycles of a drive phase, the synchronized trip input is ignored, which gives a minimum on-time.
- R5: After blanking, a synchronized trip ends the drive phase and starts a decay.
- R6: Fast decay (`fast_decay_i`=1) reverses the drive polarity. A synchronized near-zero indication then turns all four switches off until the next period.
- R7: Slow decay (`fast_decay_i`=0) turns on both low sides until the next period. In slow decay the near-zero input has no effect.
- R8: With `en_i` low, fast mode holds all four switches off (coast), and slow mode holds both low sides on (brake).
- R9: `dac_sel_o` repeats `scale_i` one cycle later. Code 00 means 100%, 01 means 71% and 10 means 38% of full scale. Code 11 turns all gates off from the next cycle.
- R10: While `fault_i` is high, all gates are off from the next cycle.
- R11: The high side and low side of one leg are never on together, and a leg passes through an all-off cycle between them.
- R12: The trip and near-zero inputs take effect only after a two-flop synchronizer. The near-zero input has no effect during the drive phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dir_i | input | 1 | Direction select |
| en_i | input | 1 | Bridge enable, active high, may carry speed PWM |
| scale_i | input | 2 | Current scale code, 11 disables the bridge |
| fast_decay_i | input | 1 | 1 selects fast decay, 0 selects slow decay |
| trip_i | input | 1 | Chopping comparator output, asynchronous |
| zero_i | input | 1 | Near-zero-current indication, asynchronous |
| fault_i | input | 1 | Forces all gates off |
| hs_a_o | output | 1 | Leg A high-side gate enable |
| ls_a_o | output | 1 | Leg A low-side gate enable |
| hs_b_o | output | 1 | Leg B high-side gate enable |
| ls_b_o | output | 1 | Leg B low-side gate enable |
| dac_sel_o | output | 2 | Reference DAC select |

## Verification
The bench sends a trip pulse inside the blanking window. A design that counted the blank wrongly would end the drive phase early and cut the minimum on-time. It holds the near-zero input high while the bridge drives and during slow decay. A design that decoded decay modes wrongly would float the winding or stop braking. It also reverses direction and leaves the decay state through the period restart. Both changes move each leg between high and low, so a missing guard would show as a cycle with both switches on, or as a direct high-to-low step with no all-off cycle between them.

// File: rtl/hbc_pkg.sv
package hbc_pkg;

    typedef enum logic [1:0] {
        LEG_OFF = 2'd0,
        LEG_HI  = 2'd1,
        LEG_LO  = 2'd2
    } leg_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_DRIVE = 2'd1,
        PH_DECAY = 2'd2,
        PH_REST  = 2'd3
    } phase_e;

    localparam int NUM_LEGS = 2;
    localparam logic [1:0] SCALE_OFF = 2'b11;

endpackage

// File: rtl/hbc_sync.sv
module hbc_sync #(
    parameter int WIDTH = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    typedef struct packed {
        logic [WIDTH-1:0] s1;
        logic [WIDTH-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = async_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign sync_o = st_q.s2;
endmodule

// File: rtl/hbc_period.sv
module hbc_period #(
    parameter int PERIOD_CYC = 2000
) (
    input  logic clk_i,
    input  logic rst_ni,
    output logic start_o
);
    localparam int CNT_W = (PERIOD_CYC > 1) ? $clog2(PERIOD_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD_CYC - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } per_t;

    per_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == LAST) st_d.cnt = '0;
        else                  st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign start_o = (st_q.cnt == '0);
endmodule

// File: rtl/hbc_leg_guard.sv
module hbc_leg_guard
    import hbc_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  leg_e tgt_i,
    output logic hi_o,
    output logic lo_o
);
    typedef struct packed {
        leg_e leg;
    } guard_t;

    guard_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tgt_i != st_q.leg) begin
            if (st_q.leg == LEG_OFF) st_d.leg = tgt_i;
            else                     st_d.leg = LEG_OFF;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q.leg <= LEG_OFF;
        else         st_q     <= st_d;
    end

    assign hi_o = (st_q.leg == LEG_HI);
    assign lo_o = (st_q.leg == LEG_LO);
endmodule

// File: rtl/hbridge_chop_ctrl.sv
module hbridge_chop_ctrl
    import hbc_pkg::*;
#(
    parameter int PERIOD_CYC = 2000,
    parameter int BLANK_CYC  = 188
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       dir_i,
    input  logic       en_i,
    input  logic [1:0] scale_i,
    input  logic       fast_decay_i,
    input  logic       trip_i,
    input  logic       zero_i,
    input  logic       fault_i,
    output logic       hs_a_o,
    output logic       ls_a_o,
    output logic       hs_b_o,
    output logic       ls_b_o,
    output logic [1:0] dac_sel_o
);
    localparam int BLK_W = $clog2(BLANK_CYC + 1) + 1;
    localparam logic [BLK_W-1:0] BLANK_END = BLK_W'(BLANK_CYC);

    typedef struct packed {
        phase_e           phase;
        logic [BLK_W-1:0] blank;
        logic [1:0]       dac;
    } ctl_t;

    ctl_t st_d, st_q;

    logic [1:0] sync_w;
    logic       trip_s, zero_s, start_w, active_w;
    leg_e       tgt_w [NUM_LEGS];
    logic       hi_w  [NUM_LEGS];
    logic       lo_w  [NUM_LEGS];

    hbc_sync #(.WIDTH(2)) sync_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i ({zero_i, trip_i}),
        .sync_o  (sync_w)
    );
    assign trip_s = sync_w[0];
    assign zero_s = sync_w[1];

    hbc_period #(.PERIOD_CYC(PERIOD_CYC)) period_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_o (start_w)
    );

    assign active_w = en_i && (scale_i != SCALE_OFF) && !fault_i;

    always_comb begin
        st_d     = st_q;
        st_d.dac = scale_i;
        if (!active_w) begin
            st_d.phase = PH_IDLE;
            st_d.blank = '0;
        end else if (st_q.phase != PH_DRIVE &&
                     (st_q.phase == PH_IDLE || start_w)) begin
            st_d.phase = PH_DRIVE;
            st_d.blank = '0;
        end else begin
            unique case (st_q.phase)
                PH_DRIVE: begin
                    if (st_q.blank != BLANK_END) st_d.blank = st_q.blank + 1'b1;
                    else if (trip_s)             st_d.phase = PH_DECAY;
                end
                PH_DECAY: begin
                    if (fast_decay_i && zero_s) st_d.phase = PH_REST;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.phase <= PH_IDLE;
            st_q.blank <= '0;
            st_q.dac   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        tgt_w[0] = LEG_OFF;
        tgt_w[1] = LEG_OFF;
        if (!fault_i && scale_i != SCALE_OFF) begin
            unique case (st_q.phase)
                PH_IDLE: begin
                    if (!fast_decay_i) begin
                        tgt_w[0] = LEG_LO;
                        tgt_w[1] = LEG_LO;
                    end
                end
                PH_DRIVE: begin
                    tgt_w[0] = dir_i ? LEG_HI : LEG_LO;
                    tgt_w[1] = dir_i ? LEG_LO : LEG_HI;
                end
                PH_DECAY: begin
                    if (fast_decay_i) begin
                        tgt_w[0] = dir_i ? LEG_LO : LEG_HI;
                        tgt_w[1] = dir_i ? LEG_HI : LEG_LO;
                    end else begin
                        tgt_w[0] = LEG_LO;
                        tgt_w[1] = LEG_LO;
                    end
                end
                default: ;
            endcase
        end
    end

    for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
        hbc_leg_guard guard_i (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .tgt_i  (tgt_w[g]),
            .hi_o   (hi_w[g]),
            .lo_o   (lo_w[g])
        );
    end

    assign hs_a_o    = hi_w[0];
    assign ls_a_o    = lo_w[0];
    assign hs_b_o    = hi_w[1];
    assign ls_b_o    = lo_w[1];
    assign dac_sel_o = st_q.dac;
endmodule

// File: rtl/hbc_chk.sv
module hbc_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic [1:0] scale_i,
    input logic       fault_i,
    input logic       hs_a_o,
    input logic       ls_a_o,
    input logic       hs_b_o,
    input logic       ls_b_o,
    input logic [1:0] dac_sel_o
);
    // R11
    no_shoot_a_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(hs_a_o && ls_a_o));
    // R11
    no_shoot_b_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(hs_b_o && ls_b_o));
    // R11
    gap_a_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hs_a_o |=> !ls_a_o);
    // R11
    gap_a_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ls_a_o |=> !hs_a_o);
    // R11
    gap_b_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hs_b_o |=> !ls_b_o);
    // R11
    gap_b_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ls_b_o |=> !hs_b_o);
    // R10
    fault_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fault_i |=> !(hs_a_o || ls_a_o || hs_b_o || ls_b_o));
    // R9
    scale_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (scale_i == 2'b11) |=> !(hs_a_o || ls_a_o || hs_b_o || ls_b_o));
    // R9
    dac_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (dac_sel_o == $past(scale_i)));
endmodule

bind hbridge_chop_ctrl hbc_chk chk_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scale_i   (scale_i),
    .fault_i   (fault_i),
    .hs_a_o    (hs_a_o),
    .ls_a_o    (ls_a_o),
    .hs_b_o    (hs_b_o),
    .ls_b_o    (ls_b_o),
    .dac_sel_o (dac_sel_o)
);

// File: tb/hbridge_chop_ctrl_tb_top.sv
`timescale 1ns/1ps
module hbridge_chop_ctrl_tb_top;
    localparam int PER = 40;
    localparam int BLK = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dir = 1'b1, en = 1'b0, fast = 1'b0, trip = 1'b0, zero = 1'b0, fault = 1'b0;
    logic [1:0] scale = 2'b00;
    logic hs_a, ls_a, hs_b, ls_b;
    logic [1:0] dac;

    int n_vec = 0, n_bad = 0, cycles = 0;
    bit done = 0;

    always #10 clk = ~clk;

    hbridge_chop_ctrl #(.PERIOD_CYC(PER), .BLANK_CYC(BLK)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .dir_i(dir), .en_i(en), .scale_i(scale),
        .fast_decay_i(fast), .trip_i(trip), .zero_i(zero), .fault_i(fault),
        .hs_a_o(hs_a), .ls_a_o(ls_a), .hs_b_o(hs_b), .ls_b_o(ls_b), .dac_sel_o(dac)
    );

    // Reference model: legs 0=off 1=high 2=low; phases 0 idle 1 drive 2 decay 3 rest
    int m_cnt, m_ph, m_bl, m_la, m_lb, m_dac;
    int m_t1, m_t2, m_z1, m_z2;

    function automatic int step_leg(int cur, int tgt);
        if (cur == tgt) return cur;
        if (cur == 0) return tgt;
        return 0;
    endfunction

    always @(posedge clk) begin
        int ta, tb, nph, nbl;
        if (!rst_n) begin
            m_cnt = 0; m_ph = 0; m_bl = 0; m_la = 0; m_lb = 0; m_dac = 0;
            m_t1 = 0; m_t2 = 0; m_z1 = 0; m_z2 = 0;
        end else begin
            ta = 0; tb = 0;
            if (!fault && scale != 3) begin
                if (m_ph == 0 && !fast) begin ta = 2; tb = 2; end
                if (m_ph == 1) begin ta = dir ? 1 : 2; tb = dir ? 2 : 1; end
                if (m_ph == 2) begin
                    if (fast) begin ta = dir ? 2 : 1; tb = dir ? 1 : 2; end
                    else begin ta = 2; tb = 2; end
                end
            end
            nph = m_ph; nbl = m_bl;
            if (!(en && scale != 3 && !fault)) begin nph = 0; nbl = 0; end
            else if (m_ph != 1 && (m_ph == 0 || m_cnt == 0)) begin nph = 1; nbl = 0; end
            else if (m_ph == 1) begin
                if (m_bl < BLK) nbl = m_bl + 1;
                else if (m_t2 != 0) nph = 2;
            end else if (m_ph == 2 && fast && m_z2 != 0) nph = 3;
            m_la = step_leg(m_la, ta);
            m_lb = step_leg(m_lb, tb);
            m_ph = nph; m_bl = nbl;
            m_dac = scale;
            m_cnt = (m_cnt == PER - 1) ? 0 : m_cnt + 1;
            m_t2 = m_t1; m_t1 = trip;
            m_z2 = m_z1; m_z1 = zero;
        end
    end

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int gates();
        return {28'd0, hs_a, ls_a, hs_b, ls_b};
    endfunction

    logic p_hs_a = 0, p_ls_a = 0, p_hs_b = 0, p_ls_b = 0;

    // Per-cycle comparison against the model, plus leg guard rules (R11)
    always @(negedge clk) begin
        int exp_g;
        if (rst_n && !done) begin
            exp_g = ((m_la == 1) << 3) | ((m_la == 2) << 2) | ((m_lb == 1) << 1) | (m_lb == 2);
            chk(gates() == exp_g, "R2-model", "gates", gates(), exp_g);
            chk(dac == m_dac[1:0], "R9", "dac_sel", dac, m_dac);
            chk(!(hs_a && ls_a) && !(hs_b && ls_b), "R11", "shoot", gates(), 0);
            chk(!((p_hs_a && ls_a) || (p_ls_a && hs_a) || (p_hs_b && ls_b) || (p_ls_b && hs_b)),
                "R11", "gap", gates(), 0);
        end
        p_hs_a = hs_a; p_ls_a = ls_a; p_hs_b = hs_b; p_ls_b = ls_b;
    end

    task automatic wait_cnt(int k);
        do @(negedge clk); while (m_cnt != k);
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin : watchdog
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                n_bad++;
                $display("FAIL watchdog actual=%0d expected=<20000", cycles);
                $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
                $finish;
            end
        end
    end

    initial begin
        cyc(3);
        // R1 reset state
        chk(gates() == 0, "R1", "gates in reset", gates(), 0);
        chk(dac == 0, "R1", "dac in reset", dac, 0);
        rst_n = 1'b1;
        en = 1'b1; dir = 1'b1; fast = 1'b0; scale = 2'b00;
        // R2 drive diagonal
        wait_cnt(20);
        chk(gates() == 4'b1001, "R2", "dir=1 drive", gates(), 4'b1001);
        trip = 1; cyc(1); trip = 0;
        // R5 / R7 slow decay
        wait_cnt(30);
        chk(gates() == 4'b0101, "R7", "slow decay", gates(), 4'b0101);
        // R3 restart
        wait_cnt(15);
        chk(gates() == 4'b1001, "R3", "new period drive", gates(), 4'b1001);
        // R4 blanking: trip inside blank window is ignored
        wait_cnt(30); trip = 1; cyc(1); trip = 0;
        wait_cnt(1); trip = 1; wait_cnt(4); trip = 0;
        wait_cnt(20);
        chk(gates() == 4'b1001, "R4", "trip in blank ignored", gates(), 4'b1001);
        // R2 reverse direction
        dir = 0; cyc(5);
        chk(gates() == 4'b0110, "R2", "dir=0 drive", gates(), 4'b0110);
        dir = 1;
        // R6 fast decay
        wait_cnt(10); fast = 1;
        wait_cnt(20); trip = 1; cyc(1); trip = 0;
        wait_cnt(28);
        chk(gates() == 4'b0110, "R6", "fast decay reversed", gates(), 4'b0110);
        zero = 1; cyc(1); zero = 0;
        wait_cnt(36);
        chk(gates() == 4'b0000, "R6", "fast decay rest", gates(), 0);
        // R12 zero ignored during drive and slow decay
        wait_cnt(10); zero = 1;
        wait_cnt(20);
        chk(gates() == 4'b1001, "R12", "zero in drive", gates(), 4'b1001);
        fast = 0; trip = 1; cyc(1); trip = 0;
        wait_cnt(32);
        chk(gates() == 4'b0101, "R12", "zero in slow decay", gates(), 4'b0101);
        zero = 0;
        // R8 enable low brake then coast
        en = 0; cyc(6);
        chk(gates() == 4'b0101, "R8", "brake", gates(), 4'b0101);
        cyc(30);
        chk(gates() == 4'b0101, "R8", "brake held", gates(), 4'b0101);
        fast = 1; cyc(4);
        chk(gates() == 4'b0000, "R8", "coast", gates(), 0);
        // R9 scale codes
        fast = 0; en = 1; scale = 2'b11; cyc(4);
        chk(gates() == 4'b0000, "R9", "scale 11 off", gates(), 0);
        chk(dac == 2'b11, "R9", "dac 11", dac, 3);
        scale = 2'b01; cyc(8);
        chk(dac == 2'b01, "R9", "dac 01", dac, 1);
        chk(gates() == 4'b1001, "R9", "scale 01 drives", gates(), 4'b1001);
        scale = 2'b10; cyc(2);
        chk(dac == 2'b10, "R9", "dac 10", dac, 2);
        // R10 fault
        fault = 1; cyc(3);
        chk(gates() == 4'b0000, "R10", "fault off", gates(), 0);
        fault = 0; cyc(60);
        // mixed pattern under model comparison
        for (int i = 0; i < 400; i++) begin
            trip = (i % 13) == 5;
            zero = (i % 17) == 3;
            if (i % 90 == 45) dir = ~dir;
            if (i % 70 == 20) fast = ~fast;
            en = (i % 110) < 100;
            cyc(1);
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule